// File: doc/BRIEF.md
# Three-Rail Power Sequencing Controller

This block turns one enable level into three staggered rail-enable flags. When enable goes high, the flags are raised one at a time, starting with flag 1. When enable goes low, they are dropped in the opposite order. Time is measured in pulses of a slow sequencing tick, a one-cycle strobe from an external divider or oscillator. The counting logic runs on the fast system clock and counts only those strobes.

The first delay of each direction is synchronised to the tick. The first tick seen after the start event only sets the phase, and nine further ticks then close the delay. That delay therefore lasts between nine and ten tick periods, depending on where the start event falls. Each later step lasts exactly eight ticks.

Enable is handled in three ways:
- A drop before flag 1 rises discards the power-up, and a new power-up starts from scratch.
- A drop after flag 1 rises turns into an orderly reverse shutdown.
- A power-down, once started, always finishes.

A strap input inverts all three flags for regulators with active-low enables.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While reset is held, and after reset until enable is first seen high, every flag is inactive: `flag_o` equals 3'b000 with `inv_i` low, or 3'b111 with `inv_i` high. Bit 0 is flag 1 and bit 2 is flag 3.
- R2: Call the clock edge at which enable is first sampled high the start edge. The tick sampled at that edge is not counted. The next sampled tick is the phase reference. Flag 1 becomes active right after the edge that samples the ninth tick following the reference.
- R3: Flag 2 becomes active after the eighth tick sampled following the edge that raised flag 1. Flag 3 becomes active after the eighth tick following the edge that raised flag 2.
- R4: Flags change only after an edge at which `tick_i` was high. At most one flag changes per edge. The active flags always form a contiguous group starting at flag 1.
- R5: When enable is sampled low with all flags active, flag 3 is withdrawn with the same phase-reference-plus-nine-ticks timing as R2. Flag 2 is withdrawn eight ticks after flag 3, and flag 1 eight ticks after flag 2.
- R6: If enable is sampled low before flag 1 rises, no flag changes and the partial count is discarded. A later rise of enable times flag 1 per R2 from the new start edge.
- R7: If enable is sampled low after flag 1 rises but before flag 3 rises, no further flag is raised. The highest active flag is withdrawn with R2 timing measured from that edge. Each lower flag is then withdrawn eight ticks after the one above it. Enable low takes priority over a delay that completes at the same edge.
- R8: Enable going high again during a power-down has no effect until all flags are inactive. After that, a power-up begins with its start edge at the next clock edge that samples enable high.
- R9: With `inv_i` high, every bit of `flag_o` is the inverse of its active-high value. A change of `inv_i` shows on `flag_o` in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sequencing tick, one system-clock cycle wide |
| en_i | input | 1 | Sequence enable level, already synchronised to `clk_i` |
| inv_i | input | 1 | Output polarity strap: 0 gives active-high flags, 1 gives active-low flags |
| flag_o | output | NUM_RAILS (3) | Rail enable flags; bit 0 is released first and withdrawn last |

## Verification
A wrong state register or level count shows on `flag_o` at the very next tick. The flag appears early, late or out of order, and a per-clock reference model catches it at that edge. A timer that loses or gains a count shifts a flag edge by a whole tick period. Each spacing between flags is also measured in ticks and compared with eight. Mishandled enable priority or a lost power-down appears as a flag that rises while enable is low, or that does not fall. The bound properties flag these on the edge where they occur.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    // Sequencer phases
    typedef enum logic [1:0] {
        SEQ_OFF  = 2'd0,  // all flags inactive, waiting for enable
        SEQ_RISE = 2'd1,  // raising flags one by one
        SEQ_FULL = 2'd2,  // all flags active
        SEQ_FALL = 2'd3   // withdrawing flags, cannot be interrupted
    } seq_state_e;

endpackage

// File: rtl/pwr_seq_timer.sv
// Tick-based delay timer. After a start, the first tick only arms the timer
// (phase reference). After a restep the timer stays armed, so the next
// delay counts from the tick that closed the previous one.
module pwr_seq_timer #(
    parameter int FIRST_TICKS = 9,
    parameter int STEP_TICKS  = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic start_i,   // clear the count and disarm
    input  logic restep_i,  // clear the count and stay armed
    input  logic long_i,    // 1: first-delay length, 0: step length
    output logic done_o
);
    localparam int MAX_TICKS = (FIRST_TICKS > STEP_TICKS) ? FIRST_TICKS : STEP_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(FIRST_TICKS - 1);
    localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(STEP_TICKS - 1);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        tmr_d  = tmr_q;
        lim    = long_i ? LIM_LONG : LIM_SHORT;
        done_o = tick_i && tmr_q.armed && (tmr_q.cnt == lim);
        if (start_i) begin
            tmr_d.armed = 1'b0;
            tmr_d.cnt   = '0;
        end else if (restep_i) begin
            tmr_d.cnt = '0;
        end else if (tick_i) begin
            if (!tmr_q.armed) begin
                tmr_d.armed = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/pwr_seq_outputs.sv
// Level-to-flag decoder with polarity strap (R4 group shape, R9 polarity)
module pwr_seq_outputs #(
    parameter int NUM_RAILS = 3,
    parameter int LVL_W     = 2
) (
    input  logic [LVL_W-1:0]     lvl_i,
    input  logic                 inv_i,
    output logic [NUM_RAILS-1:0] flag_o
);
    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_flag
        assign flag_o[g] = (lvl_i > LVL_W'(g)) ^ inv_i;
    end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
    parameter int NUM_RAILS   = 3,
    parameter int FIRST_TICKS = 9,
    parameter int STEP_TICKS  = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 tick_i,
    input  logic                 en_i,
    input  logic                 inv_i,
    output logic [NUM_RAILS-1:0] flag_o
);
    import pwr_seq_pkg::*;

    localparam int LVL_W = $clog2(NUM_RAILS + 1);
    localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(NUM_RAILS);

    typedef struct packed {
        seq_state_e       st;
        logic [LVL_W-1:0] lvl;    // number of active flags
        logic             first;  // next withdrawal uses the first-delay length
    } seq_t;

    seq_t seq_d, seq_q;
    logic tmr_start, tmr_restep, tmr_long, tmr_done;

    always_comb begin
        seq_d      = seq_q;
        tmr_start  = 1'b0;
        tmr_restep = 1'b0;
        tmr_long   = ((seq_q.st == SEQ_RISE) && (seq_q.lvl == '0)) ||
                     ((seq_q.st == SEQ_FALL) && seq_q.first);
        unique case (seq_q.st)
            SEQ_OFF: begin
                tmr_start = 1'b1;
                if (en_i) begin
                    seq_d.st = SEQ_RISE;                    // R2 start edge
                end
            end
            SEQ_RISE: begin
                if (!en_i) begin
                    tmr_start = 1'b1;
                    if (seq_q.lvl == '0) begin
                        seq_d.st = SEQ_OFF;                 // R6 discard
                    end else begin
                        seq_d.st    = SEQ_FALL;             // R7 abort
                        seq_d.first = 1'b1;
                    end
                end else if (tmr_done) begin
                    tmr_restep = 1'b1;
                    seq_d.lvl  = seq_q.lvl + 1'b1;          // R2/R3 release
                    if (seq_q.lvl == LVL_TOP - 1'b1) begin
                        seq_d.st = SEQ_FULL;
                    end
                end
            end
            SEQ_FULL: begin
                tmr_start = 1'b1;
                if (!en_i) begin
                    seq_d.st    = SEQ_FALL;                 // R5
                    seq_d.first = 1'b1;
                end
            end
            SEQ_FALL: begin
                // R8: enable is not looked at until all flags are inactive
                if (tmr_done) begin
                    tmr_restep  = 1'b1;
                    seq_d.lvl   = seq_q.lvl - 1'b1;
                    seq_d.first = 1'b0;
                    if (seq_q.lvl == LVL_W'(1)) begin
                        seq_d.st = SEQ_OFF;
                    end
                end
            end
            default: seq_d.st = SEQ_OFF;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{st: SEQ_OFF, lvl: '0, first: 1'b0};   // R1
        end else begin
            seq_q <= seq_d;
        end
    end

    pwr_seq_timer #(
        .FIRST_TICKS(FIRST_TICKS),
        .STEP_TICKS (STEP_TICKS)
    ) i_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_i),
        .start_i  (tmr_start),
        .restep_i (tmr_restep),
        .long_i   (tmr_long),
        .done_o   (tmr_done)
    );

    pwr_seq_outputs #(
        .NUM_RAILS(NUM_RAILS),
        .LVL_W    (LVL_W)
    ) i_outputs (
        .lvl_i  (seq_q.lvl),
        .inv_i  (inv_i),
        .flag_o (flag_o)
    );

endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk #(
    parameter int NUM_RAILS = 3
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 tick_i,
    input logic                 en_i,
    input logic                 inv_i,
    input logic [NUM_RAILS-1:0] flag_o
);
    logic [NUM_RAILS-1:0] act;
    logic [NUM_RAILS:0]   act_inc;

    assign act     = flag_o ^ {NUM_RAILS{inv_i}};
    assign act_inc = {1'b0, act} + 1'b1;

    // R4: active flags are a contiguous group from flag 1
    p_group_shape_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_inc[NUM_RAILS-1:0] & act) == '0);

    // R4: at most one flag moves per edge
    p_one_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(act ^ $past(act)) <= 1);

    // R4: no movement without a sampled tick
    p_tick_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> (act == $past(act)));

    // R7: nothing is raised while enable is low
    p_no_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> ((act & ~$past(act)) == '0));

    // R6: an inactive block with enable low stays inactive
    p_stay_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((act == '0) && !en_i) |=> (act == '0));
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(.NUM_RAILS(NUM_RAILS)) i_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .en_i   (en_i),
    .inv_i  (inv_i),
    .flag_o (flag_o)
);

// File: tb/test_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module test_pwr_seq_ctrl;
    localparam int NR = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          en = 1'b0;
    logic          inv = 1'b0;
    logic [NR-1:0] flag;

    int    checks = 0;
    int    errors = 0;
    int    tick_per = 5;
    bit    finished = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;   // 200 MHz

    pwr_seq_ctrl i_pwr_seq_ctrl (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .tick_i (tick),
        .en_i   (en),
        .inv_i  (inv),
        .flag_o (flag)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Tick generator: one strobe every tick_per cycles
    initial begin
        int tcnt = 0;
        forever begin
            @(negedge clk);
            if (tcnt >= tick_per - 1) begin
                tick = 1'b1;
                tcnt = 0;
            end else begin
                tick = 1'b0;
                tcnt++;
            end
        end
    end

    // Behavioural reference: mode 0 off, 1 powering up, 2 on, 3 powering down
    initial begin
        int m_mode = 0, m_lvl = 0, m_ticks = 0, m_need = 10;
        int since = 0, last_dir = 0;
        logic [NR-1:0] prev_act = '0;
        forever begin
            @(posedge clk);
            if (!rst_n) begin
                m_mode = 0; m_lvl = 0; m_ticks = 0;
                since = 0; last_dir = 0; prev_act = '0;
            end else begin
                if (tick) since++;
                case (m_mode)
                    0: if (en) begin m_mode = 1; m_ticks = 0; m_need = 10; end
                    1: begin
                        if (!en) begin
                            if (m_lvl == 0) m_mode = 0;
                            else begin m_mode = 3; m_ticks = 0; m_need = 10; end
                        end else if (tick) begin
                            m_ticks++;
                            if (m_ticks == m_need) begin
                                m_lvl++; m_ticks = 0; m_need = 8;
                                if (m_lvl == NR) m_mode = 2;
                            end
                        end
                    end
                    2: if (!en) begin m_mode = 3; m_ticks = 0; m_need = 10; end
                    default: if (tick) begin
                        m_ticks++;
                        if (m_ticks == m_need) begin
                            m_lvl--; m_ticks = 0; m_need = 8;
                            if (m_lvl == 0) m_mode = 0;
                        end
                    end
                endcase
                #1;
                chk(cur_req, flag, ((32'd1 << m_lvl) - 1) ^ {29'd0, {NR{inv}}});
                begin
                    logic [NR-1:0] act;
                    act = flag ^ {NR{inv}};
                    if (act != prev_act) begin
                        if (act > prev_act) begin
                            if (last_dir == 1) chk("R3 step", since, 8);
                            last_dir = 1;
                        end else begin
                            if (last_dir == -1) chk("R5 step", since, 8);
                            last_dir = -1;
                        end
                        since = 0;
                        prev_act = act;
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        cycles(4);
        chk("R1 in reset", flag, 3'b000);
        rst_n = 1'b1;
        cycles(10);
        chk("R1 after reset", flag, 3'b000);

        // Full power-up then power-down
        cur_req = "R2"; en = 1'b1; cycles(145);
        chk("R3 all up", flag, 3'b111);
        cur_req = "R5"; en = 1'b0; cycles(145);
        chk("R5 all down", flag, 3'b000);

        // Early drop before flag 1, then restart
        cur_req = "R6"; tick_per = 4;
        en = 1'b1; cycles(20);
        en = 1'b0; cycles(10);
        chk("R6 no flag", flag, 3'b000);
        en = 1'b1; cycles(120);
        chk("R6 restart up", flag, 3'b111);
        en = 1'b0; cycles(130);

        // Aborts after flag 1 and after flag 2
        cur_req = "R7"; tick_per = 5;
        en = 1'b1; cycles(70);
        chk("R7 only flag1", flag, 3'b001);
        en = 1'b0; cycles(120);
        chk("R7 abort1 done", flag, 3'b000);
        en = 1'b1; cycles(110);
        chk("R7 flag1+2", flag, 3'b011);
        en = 1'b0; cycles(150);
        chk("R7 abort2 done", flag, 3'b000);

        // Enable back during power-down
        cur_req = "R8";
        en = 1'b1; cycles(145);
        en = 1'b0; cycles(70);
        en = 1'b1; cycles(30);
        chk("R8 still falling", flag, 3'b001);
        cycles(220);
        chk("R8 back up", flag, 3'b111);
        en = 1'b0; cycles(145);

        // Inverted polarity
        cur_req = "R9"; inv = 1'b1; cycles(2);
        chk("R9 idle inverted", flag, 3'b111);
        en = 1'b1; cycles(145);
        chk("R9 all up inverted", flag, 3'b000);
        inv = 1'b0; #1;
        chk("R9 strap same cycle", flag, 3'b111);
        cycles(1); inv = 1'b1; cycles(1);
        en = 1'b0; cycles(145);
        chk("R9 down inverted", flag, 3'b111);
        inv = 1'b0;

        // Dense and sparse ticks
        cur_req = "R4"; tick_per = 1;
        en = 1'b1; cycles(40);
        chk("R4 dense up", flag, 3'b111);
        en = 1'b0; cycles(40);
        tick_per = 7;
        en = 1'b1; cycles(200);
        en = 1'b0; cycles(200);
        chk("R4 sparse down", flag, 3'b000);

        summary();
    end
endmodule